// File: doc/BRIEF.md
# CAN Operating-Mode and Status-Flag Controller

This block tracks two operating modes of a CAN controller: the low-power sleep (doze) mode and the configuration freeze mode. It also holds the controller's activity indications and three sticky interrupt flags. Software asks for a mode with a request level. The block grants the mode only when the transmit and receive engines are both idle, and shows the grant on an acknowledge output. When the request is withdrawn, the block waits until the bus has shown a run of consecutive recessive bits, sampled on the bit-time strobe, and only then drops the acknowledge.

The flags record entry into sleep, an exit from sleep (or a start-of-frame seen while asleep), and enabled error conditions. Software clears them by writing ones through a small write port. A single registered status-change interrupt combines the three flags. The controller leaves reset in sleep mode.

Top module: `can_mode_flags`

## Requirements
- R1: In the cycle after a synchronous reset, `doze_ack` is 1, and `freeze_ack`, `tx_active`, `rx_active`, all three flags and `status_irq` are 0.
- R2: When a mode's acknowledge is 0, the acknowledge becomes 1 at the clock edge where three things hold together: its request (`sleep_req` or `freeze_req`) is 1, `tx_busy` is 0 and `rx_busy` is 0. It never rises at an edge where either busy input is 1.
- R3: When a mode's acknowledge is 1 and its request is 0, the block counts strobed RX samples (`bit_strobe`=1). A sample with `rx_bit`=1 adds one. A sample with `rx_bit`=0 restarts the count at zero. Cycles without the strobe leave the count unchanged. The acknowledge drops at the edge that takes the REC_BITS-th (default 11) consecutive recessive sample. If the request is reasserted, the count restarts at zero.
- R4: If a request is dropped while the block is still waiting for the busy inputs to clear, the entry is cancelled and the acknowledge stays 0.
- R5: `tx_active` and `rx_active` equal `tx_busy` and `rx_busy`, delayed by one clock.
- R6: The enter-sleep flag (write-clear bit 0) sets at the edge where `doze_ack` rises, provided `ien_enter_doze` is 1. It is cleared by hardware at the edge where `doze_ack` falls.
- R7: The exit-sleep flag (write-clear bit 1) sets at the edge where `doze_ack` falls. It also sets at any edge where `sof_det` is 1 while `doze_ack` is 1. It sets regardless of `ien_exit_doze`.
- R8: The error flag (write-clear bit 2) sets at any edge where some bit of `err_status & err_ien` is 1.
- R9: An edge with `wr_en`=1 clears each flag whose bit in `wr_data` is 1. A 0 bit leaves that flag unchanged. No write affects the acknowledge or activity outputs.
- R10: If a flag's set condition and its clear (by software or by hardware) occur at the same edge, the flag ends up 1.
- R11: `status_irq` is registered. At each edge it takes the value enter-flag OR error-flag OR (exit-flag AND `ien_exit_doze`), using the flag values that edge produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Software request for sleep mode |
| freeze_req | input | 1 | Software request for freeze mode |
| ien_enter_doze | input | 1 | Enable for the enter-sleep flag |
| ien_exit_doze | input | 1 | Lets the exit-sleep flag reach the interrupt |
| err_ien | input | ERR_W | Per-source error interrupt enables |
| err_status | input | ERR_W | Per-source error status bits |
| tx_busy | input | 1 | Transmit engine busy |
| rx_busy | input | 1 | Receive engine busy |
| rx_bit | input | 1 | Sampled CAN RX level (1 = recessive) |
| bit_strobe | input | 1 | One-cycle pulse per bit time |
| sof_det | input | 1 | Start-of-frame detected pulse |
| wr_en | input | 1 | Flag write strobe |
| wr_data | input | 3 | Write-one-to-clear mask: bit 0 enter, bit 1 exit, bit 2 error |
| doze_ack | output | 1 | Sleep mode acknowledge |
| freeze_ack | output | 1 | Freeze mode acknowledge |
| tx_active | output | 1 | Transmission in progress |
| rx_active | output | 1 | Reception in progress |
| enter_doze_flag | output | 1 | Sticky enter-sleep flag |
| exit_doze_flag | output | 1 | Sticky exit-sleep flag |
| err_flag | output | 1 | Sticky error flag |
| status_irq | output | 1 | Combined status-change interrupt |

## Verification
The bench builds the block with REC_BITS at its default of 11 and ERR_W set to 4. With these values, runs of ten recessive samples ended by a dominant one come up often, so the count restart is exercised. Four error sources also allow masked and unmasked status bits in the same cycle. Random traffic on the requests, the busy inputs and the strobe makes pending entries, cancellations and exits in both modes at once. Directed sequences force the exact 11-bit boundary and a set colliding with a write-clear.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  localparam int NUM_MODES   = 2;
  localparam int MODE_SLEEP  = 0;
  localparam int MODE_FREEZE = 1;

  localparam int NUM_FLAGS  = 3;
  localparam int FLAG_ENTER = 0;
  localparam int FLAG_EXIT  = 1;
  localparam int FLAG_ERR   = 2;

  typedef logic [NUM_MODES-1:0] mode_vec_t;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/can_mode_unit.sv
module can_mode_unit #(
  parameter int   REC_BITS = 11,
  parameter logic ACK_RST  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic idle,
  input  logic rx_bit,
  input  logic bit_strobe,
  output logic ack,
  output logic enter_evt,
  output logic leave_evt
);
  localparam int CNT_W = (REC_BITS > 1) ? $clog2(REC_BITS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REC_BITS - 1);

  logic [CNT_W-1:0] rec_cnt;
  logic             leaving;

  assign leaving   = ack && !req;
  assign enter_evt = !ack && req && idle;
  assign leave_evt = leaving && bit_strobe && rx_bit && (rec_cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack     <= ACK_RST;
      rec_cnt <= '0;
    end else begin
      if (enter_evt)
        ack <= 1'b1;
      else if (leave_evt)
        ack <= 1'b0;

      if (!leaving || leave_evt || (bit_strobe && !rx_bit))
        rec_cnt <= '0;
      else if (bit_strobe)
        rec_cnt <= rec_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/can_w1c_flag.sv
module can_w1c_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic sw_clr,
  input  logic hw_clr,
  output logic q,
  output logic q_next
);
  always_comb begin
    if (set)
      q_next = 1'b1;
    else if (sw_clr || hw_clr)
      q_next = 1'b0;
    else
      q_next = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_next;
  end
endmodule

// File: rtl/can_mode_flags.sv
module can_mode_flags
  import can_mode_pkg::*;
#(
  parameter int REC_BITS = 11,
  parameter int ERR_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic             freeze_req,
  input  logic             ien_enter_doze,
  input  logic             ien_exit_doze,
  input  logic [ERR_W-1:0] err_ien,
  input  logic [ERR_W-1:0] err_status,
  input  logic             tx_busy,
  input  logic             rx_busy,
  input  logic             rx_bit,
  input  logic             bit_strobe,
  input  logic             sof_det,
  input  logic             wr_en,
  input  logic [2:0]       wr_data,
  output logic             doze_ack,
  output logic             freeze_ack,
  output logic             tx_active,
  output logic             rx_active,
  output logic             enter_doze_flag,
  output logic             exit_doze_flag,
  output logic             err_flag,
  output logic             status_irq
);
  mode_vec_t req_v, ack_v, enter_v, leave_v;
  flag_vec_t set_v, hwclr_v, swclr_v, q_v, nxt_v;
  logic      idle;

  assign idle               = !tx_busy && !rx_busy;
  assign req_v[MODE_SLEEP]  = sleep_req;
  assign req_v[MODE_FREEZE] = freeze_req;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    can_mode_unit #(
      .REC_BITS (REC_BITS),
      .ACK_RST  (m == MODE_SLEEP)
    ) mode_i (
      .clk        (clk),
      .rst        (rst),
      .req        (req_v[m]),
      .idle       (idle),
      .rx_bit     (rx_bit),
      .bit_strobe (bit_strobe),
      .ack        (ack_v[m]),
      .enter_evt  (enter_v[m]),
      .leave_evt  (leave_v[m])
    );
  end

  assign doze_ack   = ack_v[MODE_SLEEP];
  assign freeze_ack = ack_v[MODE_FREEZE];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_active <= 1'b0;
      rx_active <= 1'b0;
    end else begin
      tx_active <= tx_busy;
      rx_active <= rx_busy;
    end
  end

  always_comb begin
    set_v[FLAG_ENTER]   = enter_v[MODE_SLEEP] && ien_enter_doze;
    set_v[FLAG_EXIT]    = leave_v[MODE_SLEEP] || (sof_det && ack_v[MODE_SLEEP]);
    set_v[FLAG_ERR]     = |(err_status & err_ien);
    hwclr_v             = '0;
    hwclr_v[FLAG_ENTER] = leave_v[MODE_SLEEP];
    swclr_v             = wr_en ? flag_vec_t'(wr_data) : '0;
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    can_w1c_flag flag_i (
      .clk    (clk),
      .rst    (rst),
      .set    (set_v[f]),
      .sw_clr (swclr_v[f]),
      .hw_clr (hwclr_v[f]),
      .q      (q_v[f]),
      .q_next (nxt_v[f])
    );
  end

  assign enter_doze_flag = q_v[FLAG_ENTER];
  assign exit_doze_flag  = q_v[FLAG_EXIT];
  assign err_flag        = q_v[FLAG_ERR];

  always_ff @(posedge clk) begin
    if (rst)
      status_irq <= 1'b0;
    else
      status_irq <= nxt_v[FLAG_ENTER] || nxt_v[FLAG_ERR] ||
                    (nxt_v[FLAG_EXIT] && ien_exit_doze);
  end
endmodule

// File: rtl/can_mode_flags_chk.sv
module can_mode_flags_chk #(
  parameter int ERR_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep_req,
  input logic             freeze_req,
  input logic             tx_busy,
  input logic             rx_busy,
  input logic             rx_bit,
  input logic             bit_strobe,
  input logic [ERR_W-1:0] err_ien,
  input logic [ERR_W-1:0] err_status,
  input logic             wr_en,
  input logic [2:0]       wr_data,
  input logic             doze_ack,
  input logic             freeze_ack,
  input logic             tx_active,
  input logic             enter_doze_flag,
  input logic             exit_doze_flag,
  input logic             err_flag,
  input logic             status_irq
);
  AST_DOZE_ENTRY_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(doze_ack) |-> $past(sleep_req && !tx_busy && !rx_busy)); // R2
  AST_FREEZE_ENTRY_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(freeze_ack) |-> $past(freeze_req && !tx_busy && !rx_busy)); // R2
  AST_NO_ENTRY_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
    (!doze_ack && !sleep_req) |=> !doze_ack); // R4
  AST_EXIT_ON_RECESSIVE: assert property (@(posedge clk) disable iff (rst)
    $fell(doze_ack) |-> $past(bit_strobe && rx_bit && !sleep_req)); // R3
  AST_TX_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (tx_active == $past(tx_busy))); // R5
  AST_ENTER_FLAG_HW_CLR: assert property (@(posedge clk) disable iff (rst)
    $fell(doze_ack) |-> !enter_doze_flag); // R6
  AST_EXIT_FLAG_ON_LEAVE: assert property (@(posedge clk) disable iff (rst)
    $fell(doze_ack) |-> exit_doze_flag); // R7
  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|(err_status & err_ien)) |=> err_flag); // R8
  AST_ERR_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[2] && !(|(err_status & err_ien))) |=> !err_flag); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    status_irq |-> (enter_doze_flag || exit_doze_flag || err_flag)); // R11
endmodule

bind can_mode_flags can_mode_flags_chk #(.ERR_W(ERR_W)) chk_i (
  .clk             (clk),
  .rst             (rst),
  .sleep_req       (sleep_req),
  .freeze_req      (freeze_req),
  .tx_busy         (tx_busy),
  .rx_busy         (rx_busy),
  .rx_bit          (rx_bit),
  .bit_strobe      (bit_strobe),
  .err_ien         (err_ien),
  .err_status      (err_status),
  .wr_en           (wr_en),
  .wr_data         (wr_data),
  .doze_ack        (doze_ack),
  .freeze_ack      (freeze_ack),
  .tx_active       (tx_active),
  .enter_doze_flag (enter_doze_flag),
  .exit_doze_flag  (exit_doze_flag),
  .err_flag        (err_flag),
  .status_irq      (status_irq)
);

// File: tb/can_mode_flags_tb_top.sv
`timescale 1ns/1ps
module can_mode_flags_tb_top;
  localparam int REC_BITS = 11;
  localparam int ERR_W    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b1, freeze_req = 1'b0;
  logic ien_enter_doze = 1'b0, ien_exit_doze = 1'b0;
  logic [ERR_W-1:0] err_ien = '0, err_status = '0;
  logic tx_busy = 1'b0, rx_busy = 1'b0, rx_bit = 1'b1, bit_strobe = 1'b0;
  logic sof_det = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_data = '0;
  logic doze_ack, freeze_ack, tx_active, rx_active;
  logic enter_doze_flag, exit_doze_flag, err_flag, status_irq;

  int checks = 0;
  int errors = 0;

  // reference state
  bit m_ack [2];
  int m_cnt [2];
  bit m_txa, m_rxa, m_fe, m_fx, m_fr, m_irq;

  always #2 clk = ~clk;

  can_mode_flags #(.REC_BITS(REC_BITS), .ERR_W(ERR_W)) dut_i (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .freeze_req(freeze_req),
    .ien_enter_doze(ien_enter_doze), .ien_exit_doze(ien_exit_doze),
    .err_ien(err_ien), .err_status(err_status), .tx_busy(tx_busy),
    .rx_busy(rx_busy), .rx_bit(rx_bit), .bit_strobe(bit_strobe),
    .sof_det(sof_det), .wr_en(wr_en), .wr_data(wr_data),
    .doze_ack(doze_ack), .freeze_ack(freeze_ack), .tx_active(tx_active),
    .rx_active(rx_active), .enter_doze_flag(enter_doze_flag),
    .exit_doze_flag(exit_doze_flag), .err_flag(err_flag),
    .status_irq(status_irq)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // returns 1 if the mode's acknowledge drops this edge
  function automatic bit mode_next(input int m, input bit req, output bit entered);
    bit idle = !tx_busy && !rx_busy;
    bit left = 1'b0;
    entered = 1'b0;
    if (!m_ack[m]) begin
      m_cnt[m] = 0;
      if (req && idle) begin m_ack[m] = 1'b1; entered = 1'b1; end
    end else if (req) begin
      m_cnt[m] = 0;
    end else if (bit_strobe) begin
      if (!rx_bit) m_cnt[m] = 0;
      else if (m_cnt[m] == REC_BITS - 1) begin
        m_cnt[m] = 0; m_ack[m] = 1'b0; left = 1'b1;
      end else m_cnt[m]++;
    end
    return left;
  endfunction

  task automatic model();
    bit ent_s, ent_f, lv_s, lv_f, was_asleep, se, sx, sr;
    if (rst) begin
      m_ack[0] = 1'b1; m_ack[1] = 1'b0; m_cnt[0] = 0; m_cnt[1] = 0;
      m_txa = 0; m_rxa = 0; m_fe = 0; m_fx = 0; m_fr = 0; m_irq = 0;
      return;
    end
    was_asleep = m_ack[0];
    lv_s = mode_next(0, sleep_req, ent_s);
    lv_f = mode_next(1, freeze_req, ent_f);
    m_txa = tx_busy; m_rxa = rx_busy;
    se = ent_s && ien_enter_doze;
    sx = lv_s || (sof_det && was_asleep);
    sr = |(err_status & err_ien);
    m_fe = se ? 1'b1 : ((wr_en && wr_data[0]) || lv_s) ? 1'b0 : m_fe;
    m_fx = sx ? 1'b1 : (wr_en && wr_data[1]) ? 1'b0 : m_fx;
    m_fr = sr ? 1'b1 : (wr_en && wr_data[2]) ? 1'b0 : m_fr;
    m_irq = m_fe || m_fr || (m_fx && ien_exit_doze);
  endtask

  task automatic compare();
    check(doze_ack,        m_ack[0], "R2 R3 R4 doze_ack");
    check(freeze_ack,      m_ack[1], "R2 R3 R4 freeze_ack");
    check(tx_active,       m_txa,    "R5 tx_active");
    check(rx_active,       m_rxa,    "R5 rx_active");
    check(enter_doze_flag, m_fe,     "R6 R9 R10 enter_doze_flag");
    check(exit_doze_flag,  m_fx,     "R7 R9 exit_doze_flag");
    check(err_flag,        m_fr,     "R8 R9 R10 err_flag");
    check(status_irq,      m_irq,    "R11 status_irq");
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
  endtask

  task automatic idle_inputs();
    bit_strobe = 0; sof_det = 0; wr_en = 0; wr_data = '0; err_status = '0;
  endtask

  initial begin : watchdog
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED_CA11));
    step(); step();
    rst = 1'b0;
    // R1 reset values
    check(doze_ack, 1'b1, "R1 doze_ack reset");
    check(freeze_ack | tx_active | rx_active | enter_doze_flag |
          exit_doze_flag | err_flag | status_irq, 1'b0, "R1 others reset");

    // R3: leave sleep, ten recessive then dominant restarts the count
    sleep_req = 0; ien_exit_doze = 1;
    for (int i = 0; i < 10; i++) begin bit_strobe = 1; rx_bit = 1; step(); bit_strobe = 0; step(); end
    bit_strobe = 1; rx_bit = 0; step();
    rx_bit = 1;
    for (int i = 0; i < 10; i++) begin bit_strobe = 1; step(); end
    check(doze_ack, 1'b1, "R3 still asleep after 10");
    step();
    check(doze_ack, 1'b0, "R3 left after 11th recessive");
    check(exit_doze_flag, 1'b1, "R7 exit flag on leave");
    idle_inputs();

    // R4: request while busy, then drop before idle
    tx_busy = 1; sleep_req = 1; ien_enter_doze = 1; step(); step();
    sleep_req = 0; step(); tx_busy = 0; step(); step();
    check(doze_ack, 1'b0, "R4 cancelled entry");
    // R2 R6: real entry
    sleep_req = 1; step();
    check(enter_doze_flag, 1'b1, "R6 enter flag set");
    // R10: set and clear in same edge on error flag
    err_ien = 4'b0100; err_status = 4'b0100; wr_en = 1; wr_data = 3'b100; step();
    check(err_flag, 1'b1, "R10 set beats clear");
    err_status = '0; step();
    check(err_flag, 1'b0, "R9 clear on write one");
    wr_data = 3'b000; step();
    check(enter_doze_flag, 1'b1, "R9 zero write keeps flag");
    idle_inputs();

    // random traffic
    for (int c = 0; c < 8000; c++) begin
      if ($urandom_range(39) == 0) sleep_req  = ~sleep_req;
      if ($urandom_range(49) == 0) freeze_req = ~freeze_req;
      if ($urandom_range(7) == 0)  tx_busy = ~tx_busy;
      if ($urandom_range(9) == 0)  rx_busy = ~rx_busy;
      if ($urandom_range(99) == 0) ien_enter_doze = ~ien_enter_doze;
      if ($urandom_range(99) == 0) ien_exit_doze  = ~ien_exit_doze;
      if ($urandom_range(63) == 0) err_ien = ERR_W'($urandom);
      err_status = ($urandom_range(15) == 0) ? ERR_W'($urandom) : '0;
      bit_strobe = ($urandom_range(2) == 0);
      rx_bit     = ($urandom_range(19) != 0);
      sof_det    = ($urandom_range(31) == 0);
      wr_en      = ($urandom_range(5) == 0);
      wr_data    = 3'($urandom);
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule